// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches one general-purpose pin and raises an active-high interrupt request toward a parent interrupt controller. The raw pin level passes through a polarity inversion first, so a single rising-edge or high-level detector also covers falling edges and low levels. Two configuration inputs decide whether detection is on and whether it works on edges or on levels.

Detection writes a sticky pending flag. A separate delivery-enable flag gates that flag onto the request line. Software reaches both flags through one memory-mapped word at byte address 0x800 + 8 × pin index. In that word each flag has its own write-one-to-set bit and its own write-one-to-clear bit, so software can change one flag without a read-modify-write.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset the pending flag, the enable flag and `irq_o` are all 0.
- R2: In edge mode (`det_en_i`=1, `edge_mode_i`=1), a 0→1 change of the detected level sets the pending flag at the next rising clock edge. The detected level is `pin_i` XOR `invert_i`. The flag stays set after the level falls.
- R3: With `invert_i`=1 the detected level is the inverse of the pin. In edge mode a 1→0 change of `pin_i` therefore sets the pending flag, and in level mode a low pin is seen as asserted.
- R4: In level mode (`det_en_i`=1, `edge_mode_i`=0), the pending flag takes the detected level at every clock edge. A software clear while the level is asserted leaves the flag at 1.
- R5: With `det_en_i`=0, changes on `pin_i` never change the pending flag.
- R6: A write (`wr_en_i`=1) to the word address 0x800 + 8 × `PIN_IDX` acts on the flags through `wdata_i`. Bit 0 clears pending. Bit 1 sets pending (this bit has effect outside level mode). Bit 2 clears enable. Bit 3 sets enable. The change is visible after the next clock edge.
- R7: If one write both sets and clears the same flag, the flag ends up 0. This holds for pending and for enable.
- R8: `irq_o` is 1 exactly when the pending flag and the enable flag are both 1.
- R9: While `addr_i` equals the word address, `rdata_o` carries pending in bit 0 and enable in bit 2, with every other bit 0. At any other address `rdata_o` is 0, and writes there change nothing.
- R10: In edge mode, if a detected rising edge and a software clear of pending land in the same cycle, pending ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Filtered pin level |
| invert_i | input | 1 | Polarity inversion from the pin configuration |
| det_en_i | input | 1 | Detection enable from the pin configuration |
| edge_mode_i | input | 1 | 1 selects edge detection, 0 selects level detection |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data: clear pending, set pending, clear enable, set enable (bits 0 to 3) |
| rdata_o | output | DATA_W | Read data of the interrupt word |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The embedded assertions check four properties on every cycle: in level mode the pending flag follows the previous detected level; a pending flag in edge mode stays set unless cleared; pending holds when detection is off and no write touches it; and an enable clear always wins and masks the request. The bench's scenarios show the rest. These are the exact cycle in which a rising or an inverted falling edge is caught, the outcome when a hardware edge meets a software clear, the masking by writes to a wrong address, and the read-back layout. Each is checked against a bench model across random mixes of mode, polarity and writes.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned CTL_W        = 4;
  localparam int unsigned PEND_CLR_BIT = 0;
  localparam int unsigned PEND_SET_BIT = 1;
  localparam int unsigned ENA_CLR_BIT  = 2;
  localparam int unsigned ENA_SET_BIT  = 3;
  localparam int unsigned RD_PEND_BIT  = 0;
  localparam int unsigned RD_ENA_BIT   = 2;

  typedef struct packed {
    logic ena_set;
    logic ena_clr;
    logic pend_set;
    logic pend_clr;
  } wr_strb_t;
endpackage

// File: rtl/pin_irq_decode.sv
module pin_irq_decode
  import pin_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 32'h800,
  parameter int unsigned STRIDE    = 8,
  parameter int unsigned PIN_IDX   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CTL_W-1:0]  wdata_i,
  output logic              hit_o,
  output wr_strb_t          strb_o
);
  localparam int unsigned WORD_ADDR = BASE_ADDR + STRIDE * PIN_IDX;
  localparam logic [ADDR_W-1:0] WORD_A = WORD_ADDR[ADDR_W-1:0];

  logic wr_hit;

  assign hit_o  = (addr_i == WORD_A);
  assign wr_hit = hit_o & wr_en_i;

  always_comb begin
    strb_o.pend_clr = wr_hit & wdata_i[PEND_CLR_BIT];
    strb_o.pend_set = wr_hit & wdata_i[PEND_SET_BIT];
    strb_o.ena_clr  = wr_hit & wdata_i[ENA_CLR_BIT];
    strb_o.ena_set  = wr_hit & wdata_i[ENA_SET_BIT];
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic invert_i,
  input  logic det_en_i,
  input  logic edge_mode_i,
  output logic lvl_o,
  output logic rise_o,
  output logic follow_o
);
  logic lvl, lvl_q;

  assign lvl = pin_i ^ invert_i;

  // previous level tracked always so enabling edge mode sees a clean history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign lvl_o    = lvl;
  assign rise_o   = det_en_i & edge_mode_i & lvl & ~lvl_q;
  assign follow_o = det_en_i & ~edge_mode_i;
endmodule

// File: rtl/pin_irq_flags.sv
module pin_irq_flags
  import pin_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wr_strb_t strb_i,
  input  logic     rise_i,
  input  logic     follow_i,
  input  logic     lvl_i,
  input  logic     det_en_i,
  output logic     pend_o,
  output logic     ena_o
);
  logic pend_q, pend_d, ena_q, ena_d;

  always_comb begin
    if (follow_i) begin
      pend_d = lvl_i;
    end else begin
      if (strb_i.pend_clr)      pend_d = 1'b0;
      else if (strb_i.pend_set) pend_d = 1'b1;
      else                      pend_d = pend_q;
      if (rise_i) pend_d = 1'b1;  // a hardware edge is never lost
    end
    if (strb_i.ena_clr)      ena_d = 1'b0;
    else if (strb_i.ena_set) ena_d = 1'b1;
    else                     ena_d = ena_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ena_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ena_q  <= ena_d;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;

  a_r4_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    follow_i |=> (pend_q == $past(lvl_i)));

  a_r2_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !follow_i && !strb_i.pend_clr) |=> pend_q);

  a_r5_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en_i && !strb_i.pend_clr && !strb_i.pend_set) |=> $stable(pend_q));

  a_r7_ena_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.ena_clr |=> !ena_q);
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned BASE_ADDR = 32'h800,
  parameter int unsigned STRIDE    = 8,
  parameter int unsigned PIN_IDX   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              invert_i,
  input  logic              det_en_i,
  input  logic              edge_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CTL_W-1:0]  wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic     hit, lvl, rise, follow, pend, ena;
  wr_strb_t strb;

  pin_irq_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE), .PIN_IDX(PIN_IDX)
  ) u_decode (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .hit_o(hit), .strb_o(strb)
  );

  pin_irq_detect u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .invert_i(invert_i),
    .det_en_i(det_en_i), .edge_mode_i(edge_mode_i),
    .lvl_o(lvl), .rise_o(rise), .follow_o(follow)
  );

  pin_irq_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb), .rise_i(rise),
    .follow_i(follow), .lvl_i(lvl), .det_en_i(det_en_i),
    .pend_o(pend), .ena_o(ena)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == RD_PEND_BIT) begin : g_pend
      assign rdata_o[b] = hit & pend;
    end else if (b == RD_ENA_BIT) begin : g_ena
      assign rdata_o[b] = hit & ena;
    end else begin : g_zero
      assign rdata_o[b] = 1'b0;
    end
  end

  assign irq_o = pend & ena;

  a_r8_masked_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena |-> !irq_o);
endmodule

// File: tb/pin_irq_unit_tb_top.sv
module pin_irq_unit_tb_top;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 64;
  localparam logic [ADDR_W-1:0] WA = 16'h0818;  // 0x800 + 8*3
  localparam logic [ADDR_W-1:0] OTHER = 16'h0810;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 0, inv = 0, den = 0, edg = 0, wr = 0;
  logic [ADDR_W-1:0] addr = WA;
  logic [3:0] wd = 0;
  logic [DATA_W-1:0] rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic mp = 0, me = 0, mprev = 0;

  always #10 clk = ~clk;

  pin_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .invert_i(inv),
    .det_en_i(den), .edge_mode_i(edg), .addr_i(addr), .wr_en_i(wr),
    .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(input logic [ADDR_W-1:0] a, input logic p, input logic e);
    return (a == WA) ? {61'd0, e, 1'b0, p} : 64'd0;
  endfunction

  // drive at negedge, model at posedge, settle
  task automatic cyc(input logic p_, input logic i_, input logic d_, input logic e_,
                     input logic w_, input logic [ADDR_W-1:0] a_, input logic [3:0] wd_);
    logic lv, rise, hit, np, ne;
    @(negedge clk);
    pin = p_; inv = i_; den = d_; edg = e_; wr = w_; addr = a_; wd = wd_;
    @(posedge clk);
    lv = p_ ^ i_;
    rise = d_ & e_ & lv & ~mprev;
    hit = w_ & (a_ == WA);
    if (d_ & ~e_) np = lv;
    else begin
      if (hit & wd_[0]) np = 1'b0;
      else if (hit & wd_[1]) np = 1'b1;
      else np = mp;
      if (rise) np = 1'b1;
    end
    if (hit & wd_[2]) ne = 1'b0;
    else if (hit & wd_[3]) ne = 1'b1;
    else ne = me;
    mp = np; me = ne; mprev = lv;
    #1;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    #1;
    chk("R1 rdata", rdata, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);

    // R6 enable set, then R2 edge
    cyc(0,0,1,1,1,WA,4'b1000);
    chk("R6 ena set", rdata, 64'h4);
    cyc(1,0,1,1,0,WA,4'b0000);
    chk("R2 rise sets", rdata, 64'h5);
    chk("R8 irq on", {63'd0, irq}, 64'd1);
    cyc(0,0,1,1,0,WA,4'b0000);
    chk("R2 sticky", rdata, 64'h5);
    // R7 clear wins pending and enable
    cyc(0,0,1,1,1,WA,4'b0011);
    chk("R7 pend clr wins", rdata, 64'h4);
    cyc(0,0,1,1,1,WA,4'b1100);
    chk("R7 ena clr wins", rdata, 64'h0);
    // R6 set pending by software, R8 masked
    cyc(0,0,1,1,1,WA,4'b0010);
    chk("R6 pend set", rdata, 64'h1);
    chk("R8 masked", {63'd0, irq}, 64'd0);
    cyc(0,0,1,1,1,WA,4'b0001);
    chk("R6 pend clr", rdata, 64'h0);
    // R10 edge vs clear same cycle
    cyc(1,0,1,1,1,WA,4'b0001);
    chk("R10 hw edge wins", rdata, 64'h1);
    cyc(1,0,1,1,1,WA,4'b0001);
    chk("R2 no edge on high", rdata, 64'h0);
    // R3 falling edge via inversion: pin 1 inv 1 -> lvl 0, then pin 0 -> lvl 1
    cyc(1,1,1,1,0,WA,4'b0000);
    chk("R3 pre", rdata, 64'h0);
    cyc(0,1,1,1,0,WA,4'b0000);
    chk("R3 falling sets", rdata, 64'h1);
    // R4 level mode follows, clear no effect while high
    cyc(1,0,1,0,0,WA,4'b0000);
    chk("R4 level high", rdata, 64'h1);
    cyc(1,0,1,0,1,WA,4'b0001);
    chk("R4 clr while high", rdata, 64'h1);
    cyc(0,0,1,0,0,WA,4'b0000);
    chk("R4 level low", rdata, 64'h0);
    cyc(0,1,1,0,0,WA,4'b0000);
    chk("R3 low level seen", rdata, 64'h1);
    // R5 detection off
    cyc(0,0,0,1,1,WA,4'b0001);
    cyc(1,0,0,1,0,WA,4'b0000);
    chk("R5 off rise", rdata, 64'h0);
    cyc(0,0,0,0,0,WA,4'b0000);
    cyc(1,0,0,0,0,WA,4'b0000);
    chk("R5 off level", rdata, 64'h0);
    // R9 other address: read 0, writes ignored
    cyc(1,0,0,0,1,OTHER,4'b1010);
    chk("R9 other rd", rdata, 64'h0);
    cyc(1,0,0,0,0,WA,4'b0000);
    chk("R9 other wr ignored", rdata, 64'h0);

    // random mix
    void'($urandom(32'h5eed));
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] r;
      r = $urandom;
      a = (r[20:18] == 3'd0) ? OTHER : WA;
      cyc(r[0], r[1] & r[2], r[3] | r[4], r[5] | r[6], r[7], a, r[11:8]);
      chk("R8 rnd irq", {63'd0, irq}, {63'd0, mp & me});
      chk("R9 rnd rd", rdata, exp_rd(a, mp, me));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule